// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Run-Time Write Policy

This block is a small direct-mapped data cache between a processor request port and a slower line-wide memory port. A two-bit configuration input selects how processor writes are handled: write-through, write-back or write-around. A second input selects whether a write miss allocates the line (fetch, then merge the write) or bypasses the cache. Both settings are sampled with each accepted request, so software can change them between any two accesses.

The processor side uses a request/ready handshake. A request is accepted in a cycle where `cpu_req` and `cpu_rdy` are both high, and read data comes back on a one-cycle `cpu_rvalid` pulse. The memory side carries one whole line per transaction, with per-word write strobes. A request is held until `mem_rdy` accepts it, and read data returns later on `mem_rvalid`. The cache is blocking: `cpu_rdy` stays low until every memory transaction needed by the current access has finished. Hit and miss pulses are produced for each accepted access, so hit rate can be counted outside the block.

Address layout (word address): the low `OFF_W` bits select the word in a line, the next `IDX_W` bits select the cache line, and the remaining bits are the tag. Bit i of `mem_wstrb` enables word i of the line. `cfg_wmode` encodings: 0 = write-through, 1 = write-back, 2 = write-around, 3 = treated as write-through.

Top module: `cache_wpol`

## Requirements
- R1: After reset every line is invalid and clean: `cpu_rdy`=1, `mem_req`=0, `cpu_rvalid`=0, and the first read of any address reports a miss.
- R2: A read that hits raises `hit_pulse` in its acceptance cycle and returns the word on `cpu_rvalid`/`cpu_rdata` in the next cycle, with no memory transaction.
- R3: A read miss issues one line read, installs the line clean, and returns the requested word (the latest value written to that address) when the fill completes. Later reads of that line hit.
- R4: With `cfg_wmode`=0 (or 3), a write hit updates the cached word and issues one memory write with a single word strobe. `cpu_rdy` stays low until memory accepts that write.
- R5: With `cfg_wmode`=1, a write hit updates only the cache and marks the line dirty. No memory transaction occurs and `cpu_rdy` stays high.
- R6: When a miss must replace a valid dirty line, the whole old line is written to memory (all strobes set) before the fill read is issued.
- R7: With `cfg_wmode`=2, writes go to memory and never fill the cache. A write that hits invalidates the line, and if that line was dirty the write carries the full merged line with all strobes set. A later read misses and fills.
- R8: With `cfg_walloc`=1 and mode 0 or 1, a write miss fetches the line and merges the word into it. In mode 1 the line becomes dirty with no memory write. In mode 0 the line stays clean and one word write follows the fill.
- R9: With `cfg_walloc`=0 and mode 0 or 1, a write miss issues one word write and reads nothing. The line already resident at that index stays resident and keeps hitting.
- R10: While any memory transaction is pending `cpu_rdy` is low. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_rdy` accepts.
- R11: Dirty bits are set only by write-back writes. Changing the mode does not flush them, and a dirty line is still written back when it is evicted under another mode.
- R12: Every accepted access raises exactly one of `hit_pulse` or `miss_pulse`, in its acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wmode | input | 2 | Write mode: 0 through, 1 back, 2 around, 3 as 0 |
| cfg_walloc | input | 1 | 1 = allocate on write miss |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdy | output | 1 | Request accepted when high with `cpu_req` |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | DATA_W | Read data |
| hit_pulse | output | 1 | Accepted access hit |
| miss_pulse | output | 1 | Accepted access missed |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W-OFF_W | Line address |
| mem_wstrb | output | 2**OFF_W | Per-word write enables |
| mem_wdata | output | DATA_W*2**OFF_W | Line write data |
| mem_rdy | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Line read data valid |
| mem_rdata | input | DATA_W*2**OFF_W | Line read data |

## Verification
The hardest case to reach is a write-around hit on a line that an earlier write-back write made dirty. If the block wrote only the single word there, the rest of the dirty line would be lost. The stimulus reaches this case in three steps: an allocating write-back write miss, then a write-back hit on the other word of the same line, then a write-around write to the first word. A read of the untouched word afterwards must miss and return the write-back value from memory. A similar chain checks eviction after a mode change: a line is left dirty, the mode is switched to write-through, and a conflicting read is issued. That read must cause a full-line write before the fill read.

// File: rtl/cache_wpol_pkg.sv
package cache_wpol_pkg;
  typedef enum logic [1:0] {
    WM_THRU   = 2'd0,
    WM_BACK   = 2'd1,
    WM_AROUND = 2'd2
  } wmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_FILLW,
    ST_WRMEM
  } cst_e;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  // state bits cleared by reset; payload arrays need no reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_line;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_line  = data_q[rd_idx];
endmodule

// File: rtl/cache_tagcmp.sv
module cache_tagcmp #(
  parameter int TAG_W = 6
) (
  input  logic             line_valid,
  input  logic             line_dirty,
  input  logic [TAG_W-1:0] line_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit,
  output logic             need_evict
);
  assign hit        = line_valid && (line_tag == req_tag);
  assign need_evict = line_valid && line_dirty;
endmodule

// File: rtl/cache_wpol.sv
module cache_wpol
  import cache_wpol_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      cfg_wmode,
  input  logic                            cfg_walloc,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic                            cpu_rdy,
  output logic                            cpu_rvalid,
  output logic [DATA_W-1:0]               cpu_rdata,
  output logic                            hit_pulse,
  output logic                            miss_pulse,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-OFF_W-1:0]         mem_addr,
  output logic [(1<<OFF_W)-1:0]           mem_wstrb,
  output logic [DATA_W*(1<<OFF_W)-1:0]    mem_wdata,
  input  logic                            mem_rdy,
  input  logic                            mem_rvalid,
  input  logic [DATA_W*(1<<OFF_W)-1:0]    mem_rdata
);
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] f_word(input logic [LINE_W-1:0] ln,
                                               input logic [OFF_W-1:0] off);
    return ln[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] f_merge(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] off,
                                                input logic [DATA_W-1:0] w);
    logic [LINE_W-1:0] r;
    r = ln;
    r[off*DATA_W +: DATA_W] = w;
    return r;
  endfunction

  cst_e                state;
  logic                rq_we;
  logic                rq_alloc;
  wmode_e              rq_mode;
  logic [ADDR_W-1:0]   rq_addr;
  logic [DATA_W-1:0]   rq_wdata;
  logic [LINE_W-1:0]   wline_q;
  logic [WORDS-1:0]    wstrb_q;
  logic                rsp_v_q;
  logic [DATA_W-1:0]   rsp_d_q;

  // named internal events, shared by the datapath and the assertions
  logic                acc;
  logic                idle;
  wmode_e              mode_in;
  wmode_e              cur_mode;
  logic                cur_alloc;
  logic [ADDR_W-1:0]   lk_addr;
  logic [DATA_W-1:0]   cur_wdata;
  logic                lk_valid;
  logic                lk_dirty;
  logic [TAG_W-1:0]    lk_tag;
  logic [LINE_W-1:0]   lk_line;
  logic                lk_hit;
  logic                lk_evict;
  logic [LINE_W-1:0]   word_line;
  logic [WORDS-1:0]    one_strb;
  logic [LINE_W-1:0]   merged;

  logic                st_we;
  logic                st_valid;
  logic                st_dirty;
  logic [LINE_W-1:0]   st_line;

  cst_e                nxt_state;
  logic [LINE_W-1:0]   nxt_wline;
  logic [WORDS-1:0]    nxt_wstrb;
  logic                nxt_rsp_v;
  logic [DATA_W-1:0]   nxt_rsp_d;

  assign idle      = (state == ST_IDLE);
  assign cpu_rdy   = idle;
  assign acc       = cpu_req && cpu_rdy;
  assign mode_in   = (cfg_wmode == 2'd3) ? WM_THRU : wmode_e'(cfg_wmode);
  assign cur_mode  = idle ? mode_in : rq_mode;
  assign cur_alloc = idle ? cfg_walloc : rq_alloc;
  assign lk_addr   = idle ? cpu_addr : rq_addr;
  assign cur_wdata = idle ? cpu_wdata : rq_wdata;
  assign word_line = f_merge('0, f_off(lk_addr), cur_wdata);
  assign one_strb  = WORDS'(1) << f_off(lk_addr);
  assign merged    = f_merge(lk_line, f_off(lk_addr), cur_wdata);

  cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_idx(lk_addr)),
    .rd_valid (lk_valid),
    .rd_dirty (lk_dirty),
    .rd_tag   (lk_tag),
    .rd_line  (lk_line),
    .wr_en    (st_we),
    .wr_idx   (f_idx(lk_addr)),
    .wr_valid (st_valid),
    .wr_dirty (st_dirty),
    .wr_tag   (f_tag(lk_addr)),
    .wr_line  (st_line)
  );

  cache_tagcmp #(.TAG_W(TAG_W)) u_cmp (
    .line_valid (lk_valid),
    .line_dirty (lk_dirty),
    .line_tag   (lk_tag),
    .req_tag    (f_tag(lk_addr)),
    .hit        (lk_hit),
    .need_evict (lk_evict)
  );

  always_comb begin
    nxt_state = state;
    nxt_wline = wline_q;
    nxt_wstrb = wstrb_q;
    nxt_rsp_v = 1'b0;
    nxt_rsp_d = rsp_d_q;
    st_we     = 1'b0;
    st_valid  = 1'b1;
    st_dirty  = 1'b0;
    st_line   = lk_line;
    unique case (state)
      ST_IDLE: if (acc) begin
        if (!cpu_we) begin
          if (lk_hit) begin
            nxt_rsp_v = 1'b1;
            nxt_rsp_d = f_word(lk_line, f_off(lk_addr));
          end else begin
            nxt_state = lk_evict ? ST_EVICT : ST_FILL;
          end
        end else if (cur_mode == WM_AROUND) begin
          nxt_state = ST_WRMEM;
          nxt_wline = word_line;
          nxt_wstrb = one_strb;
          if (lk_hit) begin
            st_we    = 1'b1;
            st_valid = 1'b0;
            if (lk_dirty) begin
              nxt_wline = merged;
              nxt_wstrb = '1;
            end
          end
        end else if (lk_hit) begin
          st_we    = 1'b1;
          st_line  = merged;
          st_dirty = (cur_mode == WM_BACK) ? 1'b1 : lk_dirty;
          if (cur_mode != WM_BACK) begin
            nxt_state = ST_WRMEM;
            nxt_wline = word_line;
            nxt_wstrb = one_strb;
          end
        end else if (cur_alloc) begin
          nxt_state = lk_evict ? ST_EVICT : ST_FILL;
        end else begin
          nxt_state = ST_WRMEM;
          nxt_wline = word_line;
          nxt_wstrb = one_strb;
        end
      end
      ST_EVICT: if (mem_rdy) nxt_state = ST_FILL;
      ST_FILL:  if (mem_rdy) nxt_state = ST_FILLW;
      ST_FILLW: if (mem_rvalid) begin
        st_we     = 1'b1;
        st_line   = rq_we ? f_merge(mem_rdata, f_off(lk_addr), cur_wdata) : mem_rdata;
        st_dirty  = rq_we && (rq_mode == WM_BACK);
        nxt_state = ST_IDLE;
        if (!rq_we) begin
          nxt_rsp_v = 1'b1;
          nxt_rsp_d = f_word(mem_rdata, f_off(lk_addr));
        end else if (rq_mode == WM_THRU) begin
          nxt_state = ST_WRMEM;
          nxt_wline = word_line;
          nxt_wstrb = one_strb;
        end
      end
      ST_WRMEM: if (mem_rdy) nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rq_we    <= 1'b0;
      rq_alloc <= 1'b0;
      rq_mode  <= WM_THRU;
      rq_addr  <= '0;
      rq_wdata <= '0;
      wline_q  <= '0;
      wstrb_q  <= '0;
      rsp_v_q  <= 1'b0;
      rsp_d_q  <= '0;
    end else begin
      state   <= nxt_state;
      wline_q <= nxt_wline;
      wstrb_q <= nxt_wstrb;
      rsp_v_q <= nxt_rsp_v;
      rsp_d_q <= nxt_rsp_d;
      if (acc) begin
        rq_we    <= cpu_we;
        rq_alloc <= cfg_walloc;
        rq_mode  <= mode_in;
        rq_addr  <= cpu_addr;
        rq_wdata <= cpu_wdata;
      end
    end
  end

  assign cpu_rvalid = rsp_v_q;
  assign cpu_rdata  = rsp_d_q;
  assign hit_pulse  = acc && lk_hit;
  assign miss_pulse = acc && !lk_hit;

  assign mem_req   = (state == ST_EVICT) || (state == ST_FILL) || (state == ST_WRMEM);
  assign mem_we    = (state != ST_FILL);
  assign mem_addr  = (state == ST_EVICT) ? {lk_tag, f_idx(lk_addr)} : lk_addr[ADDR_W-1:OFF_W];
  assign mem_wdata = (state == ST_EVICT) ? lk_line : wline_q;
  assign mem_wstrb = (state == ST_EVICT) ? '1 : wstrb_q;

  AST_RD_HIT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cpu_we && lk_hit |=> cpu_rvalid && cpu_rdy);                        // R2
  AST_WT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_we && lk_hit && mode_in == WM_THRU |=> mem_req && mem_we && !cpu_rdy); // R4
  AST_WB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cpu_we && lk_hit && mode_in == WM_BACK |=> !mem_req && cpu_rdy);     // R5
  AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_EVICT && mem_rdy |=> mem_req && !mem_we);                        // R6
  AST_AROUND_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !(rq_we && rq_mode == WM_AROUND));                   // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));   // R10
  AST_BLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_rdy && !hit_pulse && !miss_pulse);                         // R10
  AST_DIRTY_ONLY_WB: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && st_dirty && !(lk_hit && lk_dirty) |-> cur_mode == WM_BACK);        // R11
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_pulse, miss_pulse}) == (cpu_req && cpu_rdy ? 1 : 0));      // R12
endmodule

// File: tb/sim_cache_wpol.sv
`timescale 1ns/1ps
module sim_cache_wpol;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int OFF_W  = 1;
  localparam int WORDS  = 1 << OFF_W;
  localparam int LINE_W = DATA_W * WORDS;
  localparam int NLINES = 1 << (ADDR_W - OFF_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_wmode = 2'd0;
  logic cfg_walloc = 1'b0;
  logic cpu_req = 1'b0;
  logic cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_rdy, cpu_rvalid, hit_pulse, miss_pulse;
  logic [DATA_W-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [ADDR_W-OFF_W-1:0] mem_addr;
  logic [WORDS-1:0] mem_wstrb;
  logic [LINE_W-1:0] mem_wdata;
  logic mem_rdy, mem_rvalid;
  logic [LINE_W-1:0] mem_rdata;

  always #2 clk = ~clk;

  cache_wpol #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wmode(cfg_wmode), .cfg_walloc(cfg_walloc),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdy(cpu_rdy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_rdy(mem_rdy), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory model: accepts one cycle after a request appears, read data 2 cycles later
  logic [LINE_W-1:0] mem [NLINES];
  logic [LINE_W-1:0] rd_line;
  int rd_cnt;
  int n_wr = 0, n_rd = 0, n_ops = 0;
  bit op_log [4096];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy    <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      rd_cnt     <= 0;
    end else begin
      mem_rdy    <= mem_req && !mem_rdy;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_rdy) begin
        op_log[n_ops % 4096] <= mem_we;
        n_ops <= n_ops + 1;
        if (mem_we) begin
          for (int w = 0; w < WORDS; w++)
            if (mem_wstrb[w]) mem[mem_addr][w*DATA_W +: DATA_W] <= mem_wdata[w*DATA_W +: DATA_W];
          n_wr <= n_wr + 1;
        end else begin
          rd_line <= mem[mem_addr];
          rd_cnt  <= 2;
          n_rd    <= n_rd + 1;
        end
      end
      if (rd_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd_line;
      end
      if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
    end
  end

  // reference state, kept from the requirements
  logic [DATA_W-1:0] truth [1 << ADDR_W];
  bit              m_valid [1 << IDX_W];
  bit              m_dirty [1 << IDX_W];
  int              m_tag   [1 << IDX_W];
  logic [DATA_W-1:0] exp_q [$];

  // scoreboard monitor: every returned word is compared to the oldest expected one
  always @(negedge clk) begin
    if (rst_n && cpu_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read data", 64'(cpu_rdata), 64'h0);
      else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(cpu_rdata == e, "R3 read data", 64'(cpu_rdata), 64'(e));
      end
    end
  end

  task automatic access(input bit we, input int addr, input logic [DATA_W-1:0] wd,
                        input int mode, input bit alloc, input string rq);
    int idx, tag, m, ewr, erd, wr0, rd0, op0;
    bit hit, ev, seen;
    idx = (addr >> OFF_W) & ((1 << IDX_W) - 1);
    tag = addr >> (OFF_W + IDX_W);
    m   = (mode == 3) ? 0 : mode;
    hit = m_valid[idx] && m_tag[idx] == tag;
    ev  = 1'b0; ewr = 0; erd = 0;
    if (!we) begin
      if (!hit) begin
        ev = m_valid[idx] && m_dirty[idx];
        erd = 1; ewr = ev ? 1 : 0;
        m_valid[idx] = 1; m_dirty[idx] = 0; m_tag[idx] = tag;
      end
      exp_q.push_back(truth[addr]);
    end else begin
      truth[addr] = wd;
      if (m == 2) begin
        ewr = 1;
        if (hit) m_valid[idx] = 0;
      end else if (hit) begin
        if (m == 1) m_dirty[idx] = 1; else ewr = 1;
      end else if (alloc) begin
        ev = m_valid[idx] && m_dirty[idx];
        erd = 1; ewr = (ev ? 1 : 0) + (m == 0 ? 1 : 0);
        m_valid[idx] = 1; m_tag[idx] = tag; m_dirty[idx] = (m == 1);
      end else ewr = 1;
    end
    @(negedge clk);
    cfg_wmode = 2'(mode); cfg_walloc = alloc;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(addr); cpu_wdata = wd;
    #0.5;
    chk(cpu_rdy == 1'b1, {rq, " R10 ready before request"}, 64'(cpu_rdy), 64'h1);
    chk(hit_pulse == hit && miss_pulse == !hit, {rq, " R12 hit/miss pulse"},
        64'({hit_pulse, miss_pulse}), 64'({hit, !hit}));
    wr0 = n_wr; rd0 = n_rd; op0 = n_ops;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    seen = cpu_rvalid;
    if (!we && hit) chk(cpu_rvalid == 1'b1, {rq, " R2 hit latency"}, 64'(cpu_rvalid), 64'h1);
    if (ewr + erd > 0) chk(cpu_rdy == 1'b0, {rq, " R10 stall"}, 64'(cpu_rdy), 64'h0);
    while (!(cpu_rdy && (we || seen))) begin
      @(negedge clk);
      seen = seen || cpu_rvalid;
    end
    chk(n_wr - wr0 == ewr, {rq, " memory writes"}, 64'(n_wr - wr0), 64'(ewr));
    chk(n_rd - rd0 == erd, {rq, " memory reads"}, 64'(n_rd - rd0), 64'(erd));
    if (ev) chk(op_log[op0 % 4096] == 1'b1, {rq, " R6 writeback before fill"},
                64'(op_log[op0 % 4096]), 64'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NLINES; i++)
      for (int w = 0; w < WORDS; w++) begin
        mem[i][w*DATA_W +: DATA_W] = 32'hA000_0000 + 32'(i * WORDS + w);
        truth[i * WORDS + w] = 32'hA000_0000 + 32'(i * WORDS + w);
      end
    for (int i = 0; i < (1 << IDX_W); i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cpu_rdy == 1'b1 && mem_req == 1'b0 && cpu_rvalid == 1'b0, "R1 reset outputs",
        64'({cpu_rdy, mem_req, cpu_rvalid}), 64'b100);
    rst_n = 1'b1;

    access(0, 'h010, 0, 1, 1, "R1 first read misses");
    access(0, 'h011, 0, 1, 1, "R2 read hit");
    access(1, 'h010, 32'h1111_0001, 1, 1, "R5 write-back hit");
    access(0, 'h010, 0, 1, 1, "R5 read back cached");
    access(0, 'h020, 0, 1, 1, "R6 dirty eviction");
    access(0, 'h010, 0, 1, 1, "R3 refill after writeback");
    access(1, 'h011, 32'h2222_0002, 0, 0, "R4 write-through hit");
    access(0, 'h011, 0, 0, 0, "R4 read after write-through");
    access(1, 'h020, 32'h3333_0003, 0, 0, "R9 no-allocate miss");
    access(0, 'h010, 0, 0, 0, "R9 resident line kept");
    access(0, 'h020, 0, 0, 0, "R9 memory holds bypassed write");
    access(0, 'h010, 0, 0, 0, "R3 reload line");
    access(1, 'h010, 32'h4444_0004, 2, 1, "R7 write-around hit invalidates");
    access(0, 'h010, 0, 2, 1, "R7 read after invalidate");
    access(1, 'h032, 32'h5555_0005, 2, 1, "R7 write-around miss");
    access(0, 'h032, 0, 2, 1, "R7 no fill on write");
    access(1, 'h044, 32'h6666_0006, 1, 1, "R8 write-back allocate");
    access(0, 'h044, 0, 1, 1, "R8 allocated line hits");
    access(1, 'h056, 32'h7777_0007, 0, 1, "R8 write-through allocate");
    access(0, 'h056, 0, 0, 1, "R8 write-through allocated hits");
    access(1, 'h045, 32'h8888_0008, 1, 1, "R11 dirty again");
    access(0, 'h084, 0, 0, 1, "R11 eviction under write-through");
    access(0, 'h044, 0, 0, 1, "R11 written-back data");
    access(0, 'h045, 0, 0, 1, "R11 written-back second word");
    access(1, 'h0A6, 32'h9999_0009, 1, 1, "R8 allocate into clean slot");
    access(1, 'h0A7, 32'hAAAA_000A, 1, 1, "R5 second word dirty");
    access(1, 'h0A6, 32'hBBBB_000B, 2, 1, "R7 write-around on dirty line");
    access(0, 'h0A7, 0, 2, 1, "R7 merged line preserved");
    access(0, 'h0A6, 0, 2, 1, "R7 around data visible");
    access(1, 'h0A6, 32'hCCCC_000C, 3, 0, "R4 mode 3 as write-through");
    access(0, 'h0A6, 0, 0, 0, "R4 mode 3 data");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all reads returned", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule